// File: doc/BRIEF.md
# Unaligned Byte-Addressed Memory Access Unit

This unit sits between one requester and a synchronous single-port RAM whose words are 32 bits wide. The requester sees a byte-addressed memory. It can read or write a byte, a 16-bit word or a 32-bit long at any byte address, with no alignment rules. The RAM itself is addressed by whole longs. The unit splits each byte address into a long index and a byte offset. On a write it shifts the data into the right byte lanes and raises only the matching byte enables. On a read it shifts the returned long down to bit 0 and clears the bytes above the access size.

An access whose bytes run past the end of one long "straddles" the boundary. The unit then issues a second RAM cycle on the very next clock, to the following long, and sends or gathers the remaining bytes there. That costs exactly one extra clock. While the second cycle is on the RAM port, the unit holds its ready signal low.

A parameter chooses between two slot policies. In the fast policy, accesses that stay inside one long use a single RAM cycle. In the baseline policy, every access takes two consecutive RAM cycles, whether it straddles or not.

Top module: `ualign_mem`

## Requirements
- R1: The byte address splits into a long index, bits [18:2], and a byte offset, bits [1:0]. The first RAM cycle is driven in the same clock in which the request is accepted, using that long index.
- R2: A read returns the bytes starting at the byte offset, least significant byte first. The result is zero-extended to 32 bits according to the size code: 0 = byte, 1 = word, 2 = long, 3 = treated as long.
- R3: A write places write-data byte k in lane (offset + k) and sets byte enable bit (offset + k) only for the lanes the access covers. All other enable bits are 0, and write-data bits above the access size are ignored.
- R4: A word at offset 3, or a long at offset 1, 2 or 3, straddles. It uses a second RAM cycle on the next clock at long index + 1 (wrapping at the top of memory), which carries the remaining bytes. A byte access never straddles.
- R5: req_ready is low only during the second RAM cycle of an access, and it is high again on the clock after that.
- R6: A read response is a one-clock pulse on rsp_valid. It arrives 2 clocks after acceptance for a one-cycle access and 3 clocks after acceptance for a two-cycle access.
- R7: With ALWAYS_TWO = 1, every access takes two RAM cycles and drops ready for one clock. The second cycle of a non-straddling write carries all-zero byte enables, and read results are unchanged.
- R8: A read RAM cycle drives write enable low and all byte enables to 0.
- R9: With ALWAYS_TWO = 0, non-straddling requests are accepted on consecutive clocks, and their responses follow on consecutive clocks in order.
- R10: During reset, req_ready is high, rsp_valid is low, and the RAM is idle while no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 long |
| req_addr | input | ADDR_W (19) | Byte address |
| req_wdata | input | DATA_W (32) | Write data, right-aligned |
| rsp_valid | output | 1 | Read result valid (one-clock pulse) |
| rsp_rdata | output | DATA_W (32) | Read result, zero-extended |
| ram_en | output | 1 | RAM cycle enable |
| ram_we | output | 1 | RAM write enable |
| ram_be | output | DATA_W/8 (4) | RAM per-byte write enables |
| ram_addr | output | ADDR_W-2 (17) | RAM long index |
| ram_wdata | output | DATA_W (32) | RAM write data |
| ram_rdata | input | DATA_W (32) | RAM read data, one clock after the enabled cycle |

## Verification
The bound checker watches the cycle-level rules on every clock:
- the first RAM cycle lands on the accepted long index;
- a straddling access puts a second cycle on the next long while ready is low;
- ready never stays low for two clocks;
- reads never raise byte enables;
- the policy-specific stall and response timing holds.

Only the bench's scenarios can show the data itself: the shifted and zero-extended read values, the lane placement of written bytes, which neighbouring bytes stay untouched, and the wrap from the last long to long 0. It confirms these by reading back through the same port against a byte-level shadow of memory.

// File: rtl/ualign_pkg.sv
package ualign_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_WIDE = 2'd3
   } size_e;

   // Number of bytes an access of the given size code touches, capped at the lane count
   function automatic int unsigned size_bytes(input logic [1:0] s, input int unsigned lanes);
      int unsigned n;
      n = 32'd1 << s;
      return (n > lanes) ? lanes : n;
   endfunction

endpackage

// File: rtl/ualign_pack.sv
module ualign_pack
   import ualign_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANES  = DATA_W / 8,
   parameter int unsigned OFF_W  = $clog2(LANES)
) (
   input  logic [1:0]        size,
   input  logic [OFF_W-1:0]  off,
   input  logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0]  be_lo,
   output logic [LANES-1:0]  be_hi,
   output logic [DATA_W-1:0] data_lo,
   output logic [DATA_W-1:0] data_hi,
   output logic              straddle
);

   logic [LANES-1:0]    lane_en;
   logic [DATA_W-1:0]   masked;
   logic [2*LANES-1:0]  be_pair;
   logic [2*DATA_W-1:0] data_pair;

   for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
      localparam int unsigned LI = i;
      assign lane_en[i]       = (LI < size_bytes(size, LANES));
      assign masked[8*i +: 8] = lane_en[i] ? wdata[8*i +: 8] : 8'h00;
   end

   assign be_pair   = {{LANES{1'b0}}, lane_en} << off;
   assign data_pair = {{DATA_W{1'b0}}, masked} << {off, 3'b000};

   assign be_lo    = be_pair[LANES-1:0];
   assign be_hi    = be_pair[2*LANES-1:LANES];
   assign data_lo  = data_pair[DATA_W-1:0];
   assign data_hi  = data_pair[2*DATA_W-1:DATA_W];
   assign straddle = |be_hi;

endmodule

// File: rtl/ualign_unpack.sv
module ualign_unpack
   import ualign_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANES  = DATA_W / 8,
   parameter int unsigned OFF_W  = $clog2(LANES)
) (
   input  logic [1:0]        size,
   input  logic [OFF_W-1:0]  off,
   input  logic [DATA_W-1:0] lo,
   input  logic [DATA_W-1:0] hi,
   output logic [DATA_W-1:0] data
);

   logic [DATA_W-1:0] shifted;

   assign shifted = DATA_W'({hi, lo} >> {off, 3'b000});

   for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
      localparam int unsigned LI = i;
      assign data[8*i +: 8] = (LI < size_bytes(size, LANES)) ? shifted[8*i +: 8] : 8'h00;
   end

endmodule

// File: rtl/ualign_mem.sv
module ualign_mem
   import ualign_pkg::*;
#(
   parameter int unsigned ADDR_W     = 19,
   parameter int unsigned DATA_W     = 32,
   parameter bit          ALWAYS_TWO = 1'b0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic                            req_write,
   input  logic [1:0]                      req_size,
   input  logic [ADDR_W-1:0]               req_addr,
   input  logic [DATA_W-1:0]               req_wdata,
   output logic                            rsp_valid,
   output logic [DATA_W-1:0]               rsp_rdata,
   output logic                            ram_en,
   output logic                            ram_we,
   output logic [DATA_W/8-1:0]             ram_be,
   output logic [ADDR_W-$clog2(DATA_W/8)-1:0] ram_addr,
   output logic [DATA_W-1:0]               ram_wdata,
   input  logic [DATA_W-1:0]               ram_rdata
);

   localparam int unsigned LANES   = DATA_W / 8;
   localparam int unsigned OFF_W   = $clog2(LANES);
   localparam int unsigned LADDR_W = ADDR_W - OFF_W;

   if (DATA_W < 16 || (DATA_W % 8) != 0 || (LANES & (LANES - 1)) != 0) begin : g_bad_width
      $error("ualign_mem: DATA_W must be a power-of-two number of bytes, at least 16 bits");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ualign_mem: ADDR_W must exceed the byte-offset width");
   end

   // Request decode
   logic               accept;
   logic [OFF_W-1:0]   req_off;
   logic [LADDR_W-1:0] req_long;
   logic [LANES-1:0]   be_lo, be_hi;
   logic [DATA_W-1:0]  wd_lo, wd_hi;
   logic               straddle;
   logic               need_two;

   assign req_off  = req_addr[OFF_W-1:0];
   assign req_long = req_addr[ADDR_W-1:OFF_W];

   ualign_pack #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_pack (
      .size    (req_size),
      .off     (req_off),
      .wdata   (req_wdata),
      .be_lo   (be_lo),
      .be_hi   (be_hi),
      .data_lo (wd_lo),
      .data_hi (wd_hi),
      .straddle(straddle)
   );

   if (ALWAYS_TWO) begin : g_slot_base
      assign need_two = 1'b1;
   end else begin : g_slot_fast
      assign need_two = straddle;
   end

   // Second-slot state
   logic               ph2_q;
   logic               ph2_we_q;
   logic [LADDR_W-1:0] ph2_addr_q;
   logic [LANES-1:0]   ph2_be_q;
   logic [DATA_W-1:0]  ph2_data_q;

   assign req_ready = ~ph2_q;
   assign accept    = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph2_q      <= 1'b0;
         ph2_we_q   <= 1'b0;
         ph2_addr_q <= '0;
         ph2_be_q   <= '0;
         ph2_data_q <= '0;
      end else begin
         ph2_q <= accept & need_two;
         if (accept) begin
            ph2_we_q   <= req_write;
            ph2_addr_q <= req_long + LADDR_W'(1);
            ph2_be_q   <= req_write ? be_hi : '0;
            ph2_data_q <= wd_hi;
         end
      end
   end

   // RAM port
   assign ram_en    = accept | ph2_q;
   assign ram_we    = ph2_q ? ph2_we_q : accept & req_write;
   assign ram_addr  = ph2_q ? ph2_addr_q : req_long;
   assign ram_be    = ph2_q ? ph2_be_q : ((accept & req_write) ? be_lo : '0);
   assign ram_wdata = ph2_q ? ph2_data_q : wd_lo;

   // Read return path
   logic              rd1_q, rd1_two_q, rd2_q;
   logic [1:0]        rd_size_q;
   logic [OFF_W-1:0]  rd_off_q;
   logic [DATA_W-1:0] lo_q;
   logic [DATA_W-1:0] un_lo, un_hi, un_data;
   logic              finish;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd1_q     <= 1'b0;
         rd1_two_q <= 1'b0;
         rd2_q     <= 1'b0;
         rd_size_q <= '0;
         rd_off_q  <= '0;
         lo_q      <= '0;
      end else begin
         rd1_q     <= accept & ~req_write;
         rd1_two_q <= need_two;
         rd2_q     <= rd1_q & rd1_two_q;
         if (accept) begin
            rd_size_q <= req_size;
            rd_off_q  <= req_off;
         end
         if (rd1_q) lo_q <= ram_rdata;
      end
   end

   assign un_lo  = rd2_q ? lo_q : ram_rdata;
   assign un_hi  = rd2_q ? ram_rdata : '0;
   assign finish = (rd1_q & ~rd1_two_q) | rd2_q;

   ualign_unpack #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_unpack (
      .size(rd_size_q),
      .off (rd_off_q),
      .lo  (un_lo),
      .hi  (un_hi),
      .data(un_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= finish;
         if (finish) rsp_rdata <= un_data;
      end
   end

endmodule

// File: rtl/ualign_chk.sv
module ualign_chk
   import ualign_pkg::*;
#(
   parameter int unsigned ADDR_W     = 19,
   parameter int unsigned DATA_W     = 32,
   parameter bit          ALWAYS_TWO = 1'b0
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            req_valid,
   input logic                            req_ready,
   input logic                            req_write,
   input logic [1:0]                      req_size,
   input logic [ADDR_W-1:0]               req_addr,
   input logic                            rsp_valid,
   input logic                            ram_en,
   input logic                            ram_we,
   input logic [DATA_W/8-1:0]             ram_be,
   input logic [ADDR_W-$clog2(DATA_W/8)-1:0] ram_addr
);

   localparam int unsigned LANES   = DATA_W / 8;
   localparam int unsigned OFF_W   = $clog2(LANES);
   localparam int unsigned LADDR_W = ADDR_W - OFF_W;

   logic               acc;
   logic               crosses;
   logic [LADDR_W-1:0] long_idx;

   assign acc      = req_valid & req_ready;
   assign long_idx = req_addr[ADDR_W-1:OFF_W];
   assign crosses  = (32'(req_addr[OFF_W-1:0]) + size_bytes(req_size, LANES)) > LANES;

   p_first_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> ram_en && ram_addr == long_idx);

   p_second_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc && crosses |=> ram_en && !req_ready && ram_addr == $past(long_idx) + LADDR_W'(1));

   p_ready_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> req_ready);

   p_read_no_be_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ram_en && !ram_we |-> ram_be == '0);

   if (ALWAYS_TWO) begin : g_base
      p_always_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
         acc |=> !req_ready && ram_en);
      p_rsp_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
         acc && !req_write |=> !rsp_valid ##1 !rsp_valid ##1 rsp_valid);
   end else begin : g_fast
      p_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
         acc && !crosses |=> req_ready);
      p_rsp_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
         acc && !req_write && !crosses |=> ##1 rsp_valid);
   end

endmodule

bind ualign_mem ualign_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALWAYS_TWO(ALWAYS_TWO)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .req_write(req_write),
   .req_size (req_size),
   .req_addr (req_addr),
   .rsp_valid(rsp_valid),
   .ram_en   (ram_en),
   .ram_we   (ram_we),
   .ram_be   (ram_be),
   .ram_addr (ram_addr)
);

// File: tb/test_ualign_mem.sv
module test_ualign_mem;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int errors = 0;
   int checks = 0;

   // Fast-policy instance
   logic        a_valid = 1'b0, a_write = 1'b0;
   logic [1:0]  a_size = 2'd0;
   logic [18:0] a_addr = '0;
   logic [31:0] a_wdata = '0;
   logic        a_ready, a_rsp_valid, a_ram_en, a_ram_we;
   logic [31:0] a_rsp_rdata, a_ram_wdata;
   logic [31:0] a_ram_rdata = '0;
   logic [3:0]  a_ram_be;
   logic [16:0] a_ram_addr;

   ualign_mem i_ualign_mem (
      .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_ready(a_ready),
      .req_write(a_write), .req_size(a_size), .req_addr(a_addr), .req_wdata(a_wdata),
      .rsp_valid(a_rsp_valid), .rsp_rdata(a_rsp_rdata), .ram_en(a_ram_en), .ram_we(a_ram_we),
      .ram_be(a_ram_be), .ram_addr(a_ram_addr), .ram_wdata(a_ram_wdata), .ram_rdata(a_ram_rdata));

   // Baseline-policy instance
   logic        b_valid = 1'b0, b_write = 1'b0;
   logic [1:0]  b_size = 2'd0;
   logic [18:0] b_addr = '0;
   logic [31:0] b_wdata = '0;
   logic        b_ready, b_rsp_valid, b_ram_en, b_ram_we;
   logic [31:0] b_rsp_rdata, b_ram_wdata;
   logic [31:0] b_ram_rdata = '0;
   logic [3:0]  b_ram_be;
   logic [16:0] b_ram_addr;

   ualign_mem #(.ALWAYS_TWO(1'b1)) i_ualign_mem_base (
      .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
      .req_write(b_write), .req_size(b_size), .req_addr(b_addr), .req_wdata(b_wdata),
      .rsp_valid(b_rsp_valid), .rsp_rdata(b_rsp_rdata), .ram_en(b_ram_en), .ram_we(b_ram_we),
      .ram_be(b_ram_be), .ram_addr(b_ram_addr), .ram_wdata(b_ram_wdata), .ram_rdata(b_ram_rdata));

   // RAM models: 64 longs, byte at byte address k initialised to k[7:0]
   logic [31:0] mem_a [64];
   logic [31:0] mem_b [64];
   logic [7:0]  shadow [256];

   initial begin
      for (int i = 0; i < 64; i++) begin
         mem_a[i] = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
         mem_b[i] = mem_a[i];
      end
      for (int k = 0; k < 256; k++) shadow[k] = 8'(k);
   end

   always @(posedge clk) begin
      if (a_ram_en) begin
         if (a_ram_we) begin
            for (int l = 0; l < 4; l++)
               if (a_ram_be[l]) mem_a[a_ram_addr[5:0]][8*l +: 8] <= a_ram_wdata[8*l +: 8];
         end
         a_ram_rdata <= mem_a[a_ram_addr[5:0]];
      end
      if (b_ram_en) begin
         if (b_ram_we) begin
            for (int l = 0; l < 4; l++)
               if (b_ram_be[l]) mem_b[b_ram_addr[5:0]][8*l +: 8] <= b_ram_wdata[8*l +: 8];
         end
         b_ram_rdata <= mem_b[b_ram_addr[5:0]];
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int nbytes(input logic [1:0] sz);
      return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
   endfunction

   // One complete request on the fast instance with all checks
   task automatic run_a(input logic wr, input logic [1:0] sz, input logic [18:0] ad, input logic [31:0] wd);
      int          n;
      bit          cr;
      logic [31:0] exp;
      logic [7:0]  be8;
      int          lat;
      n   = nbytes(sz);
      cr  = (int'(ad[1:0]) + n) > 4;
      be8 = 8'(((1 << n) - 1) << ad[1:0]);
      exp = '0;
      for (int j = 0; j < n; j++) exp[8*j +: 8] = shadow[8'(ad + 19'(j))];
      @(negedge clk);
      a_valid = 1'b1; a_write = wr; a_size = sz; a_addr = ad; a_wdata = wd;
      #0.5;
      chk(a_ram_en && a_ram_addr == ad[18:2], "R1 first slot long index", 32'(a_ram_addr), 32'(ad[18:2]));
      if (wr) chk(a_ram_be == be8[3:0], "R3 first slot byte enables", 32'(a_ram_be), 32'(be8[3:0]));
      else    chk(!a_ram_we && a_ram_be == 4'h0, "R8 read enables", 32'({a_ram_we, a_ram_be}), 32'h0);
      @(negedge clk);
      a_valid = 1'b0;
      chk(a_ready == !cr, "R5 ready after accept", 32'(a_ready), 32'(!cr));
      if (cr) begin
         chk(a_ram_en && a_ram_addr == 17'(ad[18:2] + 17'd1), "R4 second slot long index",
             32'(a_ram_addr), 32'(17'(ad[18:2] + 17'd1)));
         if (wr) chk(a_ram_be == be8[7:4], "R4 second slot byte enables", 32'(a_ram_be), 32'(be8[7:4]));
      end
      if (wr) begin
         for (int j = 0; j < n; j++) shadow[8'(ad + 19'(j))] = wd[8*j +: 8];
      end else begin
         lat = 1;
         while (!a_rsp_valid && lat < 6) begin
            @(negedge clk);
            lat++;
         end
         chk(lat == (cr ? 3 : 2), "R6 read latency", 32'(lat), cr ? 32'd3 : 32'd2);
         chk(a_rsp_rdata == exp, cr ? "R4 straddling read data" : "R2 read data", a_rsp_rdata, exp);
      end
   endtask

   // {write, size, addr, wdata}
   localparam int NV = 16;
   localparam logic [53:0] VEC [NV] = '{
      {1'b0, 2'd0, 19'h00005, 32'h0},           // byte read
      {1'b0, 2'd1, 19'h00002, 32'h0},           // word, offset 2
      {1'b0, 2'd1, 19'h00003, 32'h0},           // word, offset 3 straddles
      {1'b0, 2'd2, 19'h00000, 32'h0},           // aligned long
      {1'b0, 2'd2, 19'h00001, 32'h0},           // long offsets 1..3
      {1'b0, 2'd2, 19'h00006, 32'h0},
      {1'b0, 2'd2, 19'h0000B, 32'h0},
      {1'b0, 2'd3, 19'h00008, 32'h0},           // size 3 as long
      {1'b1, 2'd0, 19'h00011, 32'hFFFF_FFAB},   // byte write, upper data ignored
      {1'b1, 2'd1, 19'h00023, 32'h1234_BEEF},   // straddling word write
      {1'b1, 2'd2, 19'h00031, 32'h1122_3344},   // straddling long write
      {1'b1, 2'd1, 19'h00042, 32'hAAAA_5566},   // in-long word write
      {1'b0, 2'd2, 19'h00010, 32'h0},
      {1'b0, 2'd2, 19'h00020, 32'h0},
      {1'b0, 2'd2, 19'h00024, 32'h0},
      {1'b0, 2'd2, 19'h00030, 32'h0}
   };

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R10 reset state
      repeat (3) @(negedge clk);
      chk(a_ready && !a_rsp_valid && !a_ram_en, "R10 reset state",
          32'({a_ready, a_rsp_valid, a_ram_en}), 32'b100);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++)
         run_a(VEC[v][53], VEC[v][52:51], VEC[v][50:32], VEC[v][31:0]);
      run_a(1'b0, 2'd1, 19'h00034, 32'h0);   // words around the long write
      run_a(1'b0, 2'd0, 19'h00043, 32'h0);

      // R4 wrap from the last long to long 0
      run_a(1'b0, 2'd2, 19'h7FFFF, 32'h0);

      // R9 back-to-back non-straddling reads
      @(negedge clk);
      a_valid = 1'b1; a_write = 1'b0; a_size = 2'd0; a_addr = 19'h00050;
      chk(a_ready, "R9 ready for first", 32'(a_ready), 32'd1);
      @(negedge clk);
      a_addr = 19'h00056;
      chk(a_ready, "R9 ready for second", 32'(a_ready), 32'd1);
      @(negedge clk);
      a_valid = 1'b0;
      chk(a_rsp_valid && a_rsp_rdata == 32'h50, "R9 first response", a_rsp_rdata, 32'h50);
      @(negedge clk);
      chk(a_rsp_valid && a_rsp_rdata == 32'h56, "R9 second response", a_rsp_rdata, 32'h56);
      @(negedge clk);
      chk(!a_rsp_valid, "R6 response is one pulse", 32'(a_rsp_valid), 32'd0);

      // R7 baseline policy: aligned word read takes two slots
      @(negedge clk);
      b_valid = 1'b1; b_write = 1'b0; b_size = 2'd1; b_addr = 19'h00004;
      @(negedge clk);
      b_valid = 1'b0;
      chk(!b_ready && b_ram_en && b_ram_addr == 17'd2, "R7 second slot on aligned read",
          32'({b_ready, b_ram_en}), 32'b01);
      @(negedge clk);
      chk(!b_rsp_valid, "R7 no early response", 32'(b_rsp_valid), 32'd0);
      @(negedge clk);
      chk(b_rsp_valid && b_rsp_rdata == 32'h0504, "R7 read result", b_rsp_rdata, 32'h0504);

      // R7 baseline write: second slot has zero enables
      @(negedge clk);
      b_valid = 1'b1; b_write = 1'b1; b_size = 2'd0; b_addr = 19'h00009; b_wdata = 32'h0000_005A;
      @(negedge clk);
      b_valid = 1'b0;
      chk(b_ram_en && b_ram_we && b_ram_be == 4'h0, "R7 second write slot enables", 32'(b_ram_be), 32'h0);
      @(negedge clk);
      b_valid = 1'b1; b_write = 1'b0; b_size = 2'd2; b_addr = 19'h00008;
      @(negedge clk);
      b_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk(b_rsp_valid && b_rsp_rdata == 32'h0B0A_5A08, "R7 write result", b_rsp_rdata, 32'h0B0A_5A08);

      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule